// File: doc/BRIEF.md
# SMBus Master SCL Timing Generator

This block produces the clock line of a two-wire bus master and decides the exact system-clock cycle in which the data line may change. The low phase of each bit is paced by an overflow strobe from an external timer. The high phase counts two such overflows. The high-phase count starts only once the real SCL line has been seen high, so a slave that stretches the clock, or a second master that pulls SCL low early, slows the bus down and never speeds it up.

Each data bit enters through a valid/ready handshake. The bit is placed on SDA only once a minimum hold time has passed after SCL falls: 3 system clocks in the standard profile and 12 in the extended profile. A bit can be marked as gated. Bits marked this way are meant for acknowledge bits and the first bit of a byte. A gated bit keeps SCL low until software gives a release strobe. SCL then rises one system clock after both the bit and the release are present. An ungated bit lets SCL rise on the first overflow strobe that comes after the setup margin: 1 clock in the standard profile, 11 clocks in the extended profile. Both outputs are open-drain enables, where 1 pulls the line low. A one-cycle done pulse marks each rising SCL edge, so that a framing controller can sample SDA.

Handshake rules: `bit_ready_o` is high while no bit is held. A bit is taken on any cycle where valid and ready are both high. At most one bit waits, either held internally or on SDA. A producer that sees ready low keeps its valid and data steady.

Top module: `smb_scl_timer`

## Requirements
- R1: After reset, `scl_oe_o`=1 (SCL pulled low), `sda_oe_o`=0 (SDA released), `bit_ready_o`=1 and `bit_done_o`=0.
- R2: While SCL is pulled low, an overflow strobe that arrives before a bit has been placed on SDA, or that arrives while a gated bit is placed, does not release SCL.
- R3: Take `f` as the cycle in which `scl_oe_o` becomes 1, and take a bit accepted at edge `f+a`. The bit reaches `sda_oe_o` (the inverse of the bit value) at edge `f+max(H,a)`. H is 3 when `ext_hold_i`=0 and 12 when it is 1. SDA never changes while SCL is released.
- R4: An ungated bit placed at edge `p` releases SCL at the first overflow edge `e` with `e >= p+S`. S is 1 in the standard profile and 11 in the extended profile. An overflow at edge `p+S-1` is ignored.
- R5: A gated bit placed at edge `p`, with its release strobe seen at edge `q`, releases SCL at edge `max(p,q)+1`. When the load and the release share a cycle, the setup is therefore exactly 1 clock.
- R6: After SCL is released, the high-phase count starts only at the edge that first samples `scl_line_i` high. Overflow strobes up to and including that edge are ignored.
- R7: Once the high phase has started, SCL is pulled low again at the edge of the second overflow strobe.
- R8: `bit_done_o` is a one-cycle pulse that follows the edge at which `scl_line_i` was first seen high after a release.
- R9: If `scl_line_i` is sampled low during the high phase, SCL is pulled low at that same edge. This keeps the clock synchronized with another master.
- R10: After a bit is accepted before its hold time has elapsed, `bit_ready_o` stays 0 until that bit is placed on SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_i | input | 1 | One-cycle overflow strobe from the bit-rate timer |
| ext_hold_i | input | 1 | 1 selects the extended setup/hold profile |
| bit_valid_i | input | 1 | A data bit is offered |
| bit_ready_o | output | 1 | The generator can take a bit |
| bit_val_i | input | 1 | Value of the offered bit |
| bit_gate_i | input | 1 | 1 marks the offered bit as gated (waits for release) |
| release_i | input | 1 | Software release strobe for gated bits |
| scl_line_i | input | 1 | Sampled level of the SCL wire |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| bit_done_o | output | 1 | One-cycle pulse at each SCL rising edge |

## Verification
The bench builds the block with its default parameters: hold of 3 or 12, setup of 1 or 11, two high-phase overflows, and 5-bit counters. At these values every profile boundary fits inside a bit of about forty cycles. The bench sweeps both profiles and both bit kinds against load offsets on either side of the hold limit. It also sweeps overflow or release timing placed exactly at, and one cycle short of, the setup limit, and stretch lengths of 0, 2 and 4 cycles. For each bit it computes the placement edge and the rise edge arithmetically. A clock-synchronization case is mixed into the sweep.

// File: rtl/smb_scl_timer_pkg.sv
package smb_scl_timer_pkg;
  typedef enum logic [1:0] {
    PH_LOW     = 2'd0,
    PH_WAIT_HI = 2'd1,
    PH_HIGH    = 2'd2
  } phase_e;
endpackage

// File: rtl/smb_scl_satcnt.sv
module smb_scl_satcnt #(
  parameter int unsigned W        = 5,
  parameter bit          RST_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_o <= RST_FULL ? TOP : '0;
    else if (clear_i)      cnt_o <= '0;
    else if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/smb_scl_sda_place.sv
module smb_scl_sda_place (
  input  logic clk,
  input  logic rst_n,
  input  logic in_low_i,
  input  logic fall_evt_i,
  input  logic hold_ok_i,
  input  logic bit_valid_i,
  input  logic bit_val_i,
  input  logic bit_gate_i,
  output logic bit_ready_o,
  output logic placed_o,
  output logic place_evt_o,
  output logic gate_o,
  output logic sda_o
);
  logic pend_v, pend_bit, pend_gate;
  logic accept, src_v, src_bit, src_gate;

  assign bit_ready_o = !pend_v;
  assign accept      = bit_valid_i && !pend_v;
  assign src_v       = pend_v || accept;
  assign src_bit     = pend_v ? pend_bit  : bit_val_i;
  assign src_gate    = pend_v ? pend_gate : bit_gate_i;
  assign place_evt_o = in_low_i && !placed_o && hold_ok_i && src_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_bit  <= 1'b1;
      pend_gate <= 1'b0;
    end else if (place_evt_o) begin
      pend_v    <= 1'b0;
    end else if (accept) begin
      pend_v    <= 1'b1;
      pend_bit  <= bit_val_i;
      pend_gate <= bit_gate_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      placed_o <= 1'b0;
      gate_o   <= 1'b0;
      sda_o    <= 1'b1;
    end else if (fall_evt_i) begin
      placed_o <= 1'b0;
    end else if (place_evt_o) begin
      placed_o <= 1'b1;
      gate_o   <= src_gate;
      sda_o    <= src_bit;
    end
  end

  AST_SDA_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_o) |-> $past(hold_ok_i)) else $error("sda moved inside hold"); // R3
  AST_SDA_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_low_i && $past(!in_low_i)) |-> $stable(sda_o)) else $error("sda moved while scl high"); // R3
  AST_ONE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_ready_o && !place_evt_o) |=> !bit_ready_o) else $error("held bit lost"); // R10
endmodule

// File: rtl/smb_scl_phase.sv
module smb_scl_phase
  import smb_scl_timer_pkg::*;
#(
  parameter int unsigned HIGH_OVF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic release_i,
  input  logic scl_line_i,
  input  logic placed_i,
  input  logic gate_i,
  input  logic setup_ok_i,
  output logic in_low_o,
  output logic fall_evt_o,
  output logic scl_oe_o,
  output logic bit_done_o
);
  localparam int unsigned HW = (HIGH_OVF > 1) ? $clog2(HIGH_OVF) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HIGH_OVF - 1);

  phase_e        state, state_nx;
  logic [HW-1:0] hiov;
  logic          rel_seen, rise_now;

  assign in_low_o   = (state == PH_LOW);
  assign scl_oe_o   = in_low_o;
  assign rise_now   = in_low_o && placed_i &&
                      (gate_i ? rel_seen : (ovf_i && setup_ok_i));
  assign fall_evt_o = (state == PH_HIGH) &&
                      (!scl_line_i || (ovf_i && hiov == HLAST));

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_LOW:     if (rise_now)   state_nx = PH_WAIT_HI;
      PH_WAIT_HI: if (scl_line_i) state_nx = PH_HIGH;
      PH_HIGH:    if (fall_evt_o) state_nx = PH_LOW;
      default:                    state_nx = PH_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= PH_LOW;
      hiov       <= '0;
      rel_seen   <= 1'b0;
      bit_done_o <= 1'b0;
    end else begin
      state      <= state_nx;
      bit_done_o <= (state == PH_WAIT_HI) && scl_line_i;
      if (state != PH_HIGH)   hiov <= '0;
      else if (ovf_i)         hiov <= hiov + 1'b1;
      if (fall_evt_o)                rel_seen <= 1'b0;
      else if (in_low_o && release_i) rel_seen <= 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done_o |=> !bit_done_o) else $error("done longer than one cycle"); // R8
  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done_o |-> $past(scl_line_i)) else $error("done without high line"); // R8
  AST_RISE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe_o) |-> $past(placed_i)) else $error("scl released with no bit"); // R2
  AST_GATE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe_o) && $past(gate_i)) |-> $past(rel_seen)) else $error("gated bit not released"); // R5
  AST_SETUP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe_o) && !$past(gate_i)) |-> $past(setup_ok_i)) else $error("setup cut short"); // R4
endmodule

// File: rtl/smb_scl_timer.sv
module smb_scl_timer #(
  parameter int unsigned HOLD_STD  = 3,
  parameter int unsigned HOLD_EXT  = 12,
  parameter int unsigned SETUP_STD = 1,
  parameter int unsigned SETUP_EXT = 11,
  parameter int unsigned HIGH_OVF  = 2,
  parameter int unsigned CW        = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic ext_hold_i,
  input  logic bit_valid_i,
  output logic bit_ready_o,
  input  logic bit_val_i,
  input  logic bit_gate_i,
  input  logic release_i,
  input  logic scl_line_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic bit_done_o
);
  localparam logic [CW-1:0] HOLD_STD_LIM  = CW'(HOLD_STD - 1);
  localparam logic [CW-1:0] HOLD_EXT_LIM  = CW'(HOLD_EXT - 1);
  localparam logic [CW-1:0] SETUP_STD_LIM = CW'(SETUP_STD - 1);
  localparam logic [CW-1:0] SETUP_EXT_LIM = CW'(SETUP_EXT - 1);

  logic [CW-1:0] hold_cnt, setup_cnt, hold_lim, setup_lim;
  logic hold_ok, setup_ok, in_low, fall_evt;
  logic placed, place_evt, gate_q, sda_q;

  assign hold_lim  = ext_hold_i ? HOLD_EXT_LIM  : HOLD_STD_LIM;
  assign setup_lim = ext_hold_i ? SETUP_EXT_LIM : SETUP_STD_LIM;
  assign hold_ok   = hold_cnt  >= hold_lim;
  assign setup_ok  = setup_cnt >= setup_lim;
  assign sda_oe_o  = !sda_q;

  smb_scl_satcnt #(.W(CW), .RST_FULL(1'b1)) u_hold_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(fall_evt), .cnt_o(hold_cnt));

  smb_scl_satcnt #(.W(CW), .RST_FULL(1'b0)) u_setup_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(place_evt), .cnt_o(setup_cnt));

  smb_scl_sda_place u_place (
    .clk(clk), .rst_n(rst_n), .in_low_i(in_low), .fall_evt_i(fall_evt),
    .hold_ok_i(hold_ok), .bit_valid_i(bit_valid_i), .bit_val_i(bit_val_i),
    .bit_gate_i(bit_gate_i), .bit_ready_o(bit_ready_o), .placed_o(placed),
    .place_evt_o(place_evt), .gate_o(gate_q), .sda_o(sda_q));

  smb_scl_phase #(.HIGH_OVF(HIGH_OVF)) u_phase (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf_i), .release_i(release_i),
    .scl_line_i(scl_line_i), .placed_i(placed), .gate_i(gate_q),
    .setup_ok_i(setup_ok), .in_low_o(in_low), .fall_evt_o(fall_evt),
    .scl_oe_o(scl_oe_o), .bit_done_o(bit_done_o));

  AST_HIGH_NO_SDA_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && $past(!scl_oe_o)) |-> $stable(sda_oe_o)) else $error("sda moved with scl high"); // R3
  AST_SYNC_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!scl_oe_o) && !scl_oe_o && !scl_line_i && $past(scl_line_i)) |=> scl_oe_o) else $error("no clock sync"); // R9
endmodule

// File: tb/test_smb_scl_timer.sv
module test_smb_scl_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovf = 1'b0, ext = 1'b0, bvalid = 1'b0, bval = 1'b0, bgate = 1'b0, rel = 1'b0;
  logic slave_low = 1'b0;
  logic bready, scl_oe, sda_oe, done;
  wire  scl_line = !scl_oe && !slave_low;

  int pc = 0;
  int errors = 0;
  int checks = 0;
  int f_cur = 0;
  logic last_bit = 1'b1;
  bit finished = 1'b0;

  always #2 clk = !clk;
  always @(posedge clk) pc <= pc + 1;

  smb_scl_timer i_smb_scl_timer (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf), .ext_hold_i(ext),
    .bit_valid_i(bvalid), .bit_ready_o(bready), .bit_val_i(bval),
    .bit_gate_i(bgate), .release_i(rel), .scl_line_i(scl_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .bit_done_o(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (pc=%0d)", req, act, exp, pc);
    end
  endtask

  // One bit slot; f_cur is the negedge index at which scl_oe was seen rising.
  task automatic run_bit(input bit chk, input bit e, input bit g, input int L,
                         input int k, input bit sync);
    int hold = e ? 12 : 3;
    int su   = e ? 11 : 1;
    int t_sda = (L + 1 > hold) ? L + 1 : hold;
    int o1, o2, rl, rt_exp, rt = -1, sda_t = -1;
    int x = 2 * k, a = k, b = 2 - k;
    int u1, u2, fall_exp, done_t = -1, done_n = 0, fall_t = -1;
    logic nb = !last_bit;
    last_bit = nb;
    if (!chk) t_sda = L + 1;
    o1 = (k == 0) ? 1 : (k == 1) ? t_sda + su - 1 : t_sda + su - 2;
    o2 = ((o1 > t_sda + su - 1) ? o1 : t_sda + su - 1) + 3;
    rl = (k == 0) ? 0 : (k == 1) ? t_sda - 1 : t_sda + 3;
    if (g) rt_exp = ((t_sda > rl + 1) ? t_sda : rl + 1) + 1;
    else   rt_exp = (o1 + 1 >= t_sda + su) ? o1 + 1 : o2 + 1;
    ext = e;
    slave_low = (x > 0);
    for (int t = 0; t < 80; t++) begin
      if (t > 0 && sda_t < 0 && sda_oe == !nb) sda_t = t;
      if (!scl_oe) begin rt = t; break; end
      if (chk && t == L) check(bready == 1'b1, "R10 ready before load", bready, 1);
      if (chk && t == L + 1) check(bready == (L + 1 >= hold), "R10 ready while held", bready, (L + 1 >= hold));
      bvalid = (t == L);
      bval   = nb;
      bgate  = g;
      ovf    = g ? (t == o1 || t == 1) : (t == o1 || t == o2);
      rel    = g && (t == rl);
      @(negedge clk);
    end
    bvalid = 1'b0; ovf = 1'b0; rel = 1'b0;
    if (chk) begin
      check(sda_t == t_sda, "R3 hold placement", sda_t, t_sda);
      check(sda_oe == !nb, "R3 sda level", sda_oe, !nb);
      if (g) check(rt == rt_exp, "R5 gated rise", rt, rt_exp);
      else   check(rt == rt_exp, "R4 R2 ungated rise", rt, rt_exp);
    end
    u1 = x + 1 + a;
    u2 = u1 + 1 + b;
    fall_exp = sync ? x + 3 : u2 + 1;
    for (int u = 0; u < 80; u++) begin
      if (done) begin done_n++; if (done_t < 0) done_t = u; end
      if (scl_oe) begin fall_t = u; break; end
      slave_low = (u < x) || (sync && u == x + 2);
      ovf = (u == 0) || (u == x) || (!sync && (u == u1 || u == u2));
      @(negedge clk);
    end
    ovf = 1'b0; slave_low = 1'b0;
    if (chk) begin
      check(done_t == x + 1 && done_n == 1, "R6 R8 done after stretch", done_t, x + 1);
      if (sync) check(fall_t == fall_exp, "R9 clock sync fall", fall_t, fall_exp);
      else      check(fall_t == fall_exp, "R7 high phase length", fall_t, fall_exp);
    end
    f_cur = pc;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl_oe == 1'b1, "R1 scl_oe reset", scl_oe, 1);
    check(sda_oe == 1'b0, "R1 sda_oe reset", sda_oe, 0);
    check(bready == 1'b1, "R1 ready reset", bready, 1);
    check(done == 1'b0, "R1 done reset", done, 0);
    rst_n = 1'b1;
    f_cur = pc;
    run_bit(1'b0, 1'b0, 1'b0, 0, 1, 1'b0);
    for (int e = 0; e < 2; e++)
      for (int g = 0; g < 2; g++)
        for (int li = 0; li < 4; li++)
          for (int k = 0; k < 3; k++) begin
            int L = (li == 0) ? 0 : (li == 1) ? 2 : (li == 2) ? 11 : 14;
            run_bit(1'b1, e[0], g[0], L, k, (li == 1 && k == 1));
          end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", pc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule